// File: doc/BRIEF.md
# Power Switch Ramp Sequencer

This block drives the 8-bit control word of the power switch that feeds one processor core. A fully closed switch is 0xFF and a fully open one is 0x00. Opening is done in graded steps so that the inrush current into the core's supply stays limited. Closing is done in one step. One instance serves one core. The block has no model of the analog switch, and arbitration between cores belongs to logic outside it.

A request is presented with `reqValid` and a direction bit (`reqOpen` high for open, low for close). It is taken on a clock edge where `reqReady` is high. An open request walks a fixed series of codes, and every code is held for `DWELL` clock cycles. If the word already reads 0x00 when the open request arrives, no code is driven and the sequence finishes immediately. At the end of every sequence a one-cycle `seqDone` pulse is given. While a sequence runs, `reqReady` is low and requests have no effect. The current control word is visible on `ctrlWord` at all times.

Top module: `pwr_ramp_seq`

## Requirements
- R1: While reset is active, and directly after it, `ctrlWord` is 0xFF, `reqReady` is 1 and `seqDone` is 0. This also holds when reset hits in the middle of a sequence.
- R2: An open request that arrives with `ctrlWord` other than 0x00 drives the codes 0xFF, 0xFE, 0xF8, 0xF0 and 0x00, in this order and with no other value between them.
- R3: The first code of a sequence appears on `ctrlWord` in the cycle after the accepting edge. Every code is then held for exactly `DWELL` cycles before the next one is driven.
- R4: `seqDone` is high for exactly one cycle, in the cycle after the dwell of the last code ends. Counting from the accepting edge, this is 5·DWELL cycles for a full open and DWELL cycles for a close. `reqReady` is low from the accepting edge until the cycle after the `seqDone` pulse.
- R5: An open request that arrives with `ctrlWord` equal to 0x00 leaves the word at 0x00. In this case `seqDone` is high in the cycle directly after the accepting edge.
- R6: A close request drives 0xFF as a single step, held for DWELL cycles, then finishes. This is the same whether the word was 0x00 or already 0xFF.
- R7: A request presented while a sequence runs is not accepted. The running sequence keeps its code series and timing.
- R8: While the block is idle and no request is presented, `reqReady` is 1 and `ctrlWord` does not change.
- R9: `ctrlWord` only ever takes one of the values 0xFF, 0xFE, 0xF8, 0xF0 or 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| reqValid | input | 1 | A request is presented |
| reqOpen | input | 1 | Request direction: 1 = open, 0 = close |
| reqReady | output | 1 | The block can take a request on this edge |
| ctrlWord | output | 8 | Power-switch control word, also the status of the switch |
| seqDone | output | 1 | One-cycle pulse when a sequence finishes |

## Verification
The hardest case to reach from the ports is the skip path of R5: it needs the word to be exactly 0x00 when an open request is taken. The stimulus gets there by chaining requests, so that a completed open is followed at once by a second open. A second hard case is R7. It is reached by holding `reqValid` high with the opposite direction during the whole ramp. The bench then checks that the code trace and the completion cycle match those of an undisturbed open. A reset in the middle of a ramp is also applied, to check that the word returns to closed at once.

// File: rtl/pwr_ramp_pkg.sv
package pwr_ramp_pkg;

  localparam int WORD_W    = 8;
  localparam int NUM_STEPS = 5;

  localparam logic [WORD_W-1:0] WORD_CLOSED = 8'hFF;
  localparam logic [WORD_W-1:0] WORD_OPEN   = 8'h00;

  // Strobes from the control FSM to the datapath
  typedef struct packed {
    logic startSeq;   // load the first code and the dwell count
    logic stepNext;   // go to the next code of the open series
  } rampStrobe_t;

  typedef enum logic [1:0] {
    S_IDLE = 2'd0,
    S_RAMP = 2'd1,
    S_FIN  = 2'd2
  } seqState_t;

  // Code driven at a given step of the open series
  function automatic logic [WORD_W-1:0] stepCode(input int unsigned idx);
    case (idx)
      0:       stepCode = 8'hFF;
      1:       stepCode = 8'hFE;
      2:       stepCode = 8'hF8;
      3:       stepCode = 8'hF0;
      default: stepCode = 8'h00;
    endcase
  endfunction

endpackage

// File: rtl/pwr_ramp_dpath.sv
module pwr_ramp_dpath
  import pwr_ramp_pkg::*;
#(
  parameter int DWELL = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  rampStrobe_t       strobe,
  output logic [WORD_W-1:0] ctrlWord,
  output logic              cntZero,
  output logic              atLast,
  output logic              wordOpen
);

  localparam int IDX_W = $clog2(NUM_STEPS);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_STEPS - 1);

  logic [IDX_W-1:0]  stepIdx;
  logic [WORD_W-1:0] wordQ;

  // Code register and step index
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wordQ   <= WORD_CLOSED;
      stepIdx <= '0;
    end else if (strobe.startSeq) begin
      wordQ   <= stepCode(0);
      stepIdx <= '0;
    end else if (strobe.stepNext) begin
      wordQ   <= stepCode(int'(stepIdx) + 1);
      stepIdx <= stepIdx + 1'b1;
    end
  end

  // Dwell counter: it is left out when every code lasts a single cycle
  generate
    if (DWELL == 1) begin : g_noWait
      assign cntZero = 1'b1;
    end else begin : g_wait
      localparam int CNT_W = $clog2(DWELL);
      localparam logic [CNT_W-1:0] CNT_RELOAD = CNT_W'(DWELL - 1);
      logic [CNT_W-1:0] dwellCnt;

      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          dwellCnt <= '0;
        end else if (strobe.startSeq || strobe.stepNext) begin
          dwellCnt <= CNT_RELOAD;
        end else if (dwellCnt != '0) begin
          dwellCnt <= dwellCnt - 1'b1;
        end
      end

      assign cntZero = (dwellCnt == '0);
    end
  endgenerate

  assign ctrlWord = wordQ;
  assign atLast   = (stepIdx == LAST_IDX);
  assign wordOpen = (wordQ == WORD_OPEN);

endmodule

// File: rtl/pwr_ramp_ctrl.sv
module pwr_ramp_ctrl
  import pwr_ramp_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        reqOpen,
  input  logic        cntZero,
  input  logic        atLast,
  input  logic        wordOpen,
  output rampStrobe_t strobe,
  output logic        reqReady,
  output logic        seqDone
);

  seqState_t state, stateNxt;
  logic      isClose, isCloseNxt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= S_IDLE;
      isClose <= 1'b0;
    end else begin
      state   <= stateNxt;
      isClose <= isCloseNxt;
    end
  end

  always_comb begin
    stateNxt        = state;
    isCloseNxt      = isClose;
    strobe.startSeq = 1'b0;
    strobe.stepNext = 1'b0;
    unique case (state)
      S_IDLE: begin
        if (reqValid) begin
          if (reqOpen && wordOpen) begin
            stateNxt = S_FIN;
          end else begin
            strobe.startSeq = 1'b1;
            isCloseNxt      = !reqOpen;
            stateNxt        = S_RAMP;
          end
        end
      end
      S_RAMP: begin
        if (cntZero) begin
          if (isClose || atLast) begin
            stateNxt = S_FIN;
          end else begin
            strobe.stepNext = 1'b1;
          end
        end
      end
      S_FIN: begin
        stateNxt = S_IDLE;
      end
      default: begin
        stateNxt = S_IDLE;
      end
    endcase
  end

  assign reqReady = (state == S_IDLE);
  assign seqDone  = (state == S_FIN);

endmodule

// File: rtl/pwr_ramp_seq.sv
module pwr_ramp_seq
  import pwr_ramp_pkg::*;
#(
  parameter int DWELL = 4
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        reqOpen,
  output logic        reqReady,
  output logic [7:0]  ctrlWord,
  output logic        seqDone
);

  rampStrobe_t strobe;
  logic        cntZero;
  logic        atLast;
  logic        wordOpen;

  pwr_ramp_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .reqOpen  (reqOpen),
    .cntZero  (cntZero),
    .atLast   (atLast),
    .wordOpen (wordOpen),
    .strobe   (strobe),
    .reqReady (reqReady),
    .seqDone  (seqDone)
  );

  pwr_ramp_dpath #(
    .DWELL (DWELL)
  ) u_dpath (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .ctrlWord (ctrlWord),
    .cntZero  (cntZero),
    .atLast   (atLast),
    .wordOpen (wordOpen)
  );

endmodule

// File: rtl/pwr_ramp_chk.sv
module pwr_ramp_chk #(
  parameter int DWELL = 4
) (
  input logic       clk,
  input logic       rstN,
  input logic       reqValid,
  input logic       reqOpen,
  input logic       reqReady,
  input logic [7:0] ctrlWord,
  input logic       seqDone
);

  localparam int HOLD_W = $clog2(DWELL + 2) + 1;
  localparam logic [HOLD_W-1:0] HOLD_SAT = HOLD_W'(DWELL + 1);

  logic [7:0]        prevWord;
  logic [HOLD_W-1:0] holdCnt;

  // Counts how many cycles the previous value of the word lasted
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevWord <= 8'hFF;
      holdCnt  <= HOLD_SAT;
    end else begin
      prevWord <= ctrlWord;
      if (ctrlWord != prevWord) holdCnt <= HOLD_W'(1);
      else if (holdCnt != HOLD_SAT) holdCnt <= holdCnt + 1'b1;
    end
  end

  function automatic logic [7:0] followCode(input logic [7:0] w);
    case (w)
      8'hFF:   followCode = 8'hFE;
      8'hFE:   followCode = 8'hF8;
      8'hF8:   followCode = 8'hF0;
      default: followCode = 8'h00;
    endcase
  endfunction

  function automatic logic legalCode(input logic [7:0] w);
    legalCode = (w == 8'hFF) || (w == 8'hFE) || (w == 8'hF8) ||
                (w == 8'hF0) || (w == 8'h00);
  endfunction

  p_order_r2: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlWord != prevWord && ctrlWord != 8'hFF) |-> (ctrlWord == followCode(prevWord)));

  p_dwell_r3: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlWord != prevWord) |-> (holdCnt >= HOLD_W'(DWELL)));

  p_done_pulse_r4: assert property (@(posedge clk) disable iff (!rstN)
    seqDone |=> !seqDone);

  p_done_busy_r4: assert property (@(posedge clk) disable iff (!rstN)
    seqDone |-> !reqReady);

  p_skip_r5: assert property (@(posedge clk) disable iff (!rstN)
    (reqReady && reqValid && reqOpen && ctrlWord == 8'h00) |=> (seqDone && ctrlWord == 8'h00));

  p_close_r6: assert property (@(posedge clk) disable iff (!rstN)
    (reqReady && reqValid && !reqOpen) |=> (ctrlWord == 8'hFF && !seqDone && !reqReady));

  p_idle_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    (reqReady && !reqValid) |=> $stable(ctrlWord));

  p_legal_r9: assert property (@(posedge clk) disable iff (!rstN)
    legalCode(ctrlWord));

endmodule

bind pwr_ramp_seq pwr_ramp_chk #(.DWELL(DWELL)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .reqValid (reqValid),
  .reqOpen  (reqOpen),
  .reqReady (reqReady),
  .ctrlWord (ctrlWord),
  .seqDone  (seqDone)
);

// File: tb/sim_pwr_ramp_seq.sv
module sim_pwr_ramp_seq;

  localparam int D = 3;
  localparam int NV = 6;

  // Stimulus table: direction, expected completion cycle, expected final word
  localparam bit VEC_OPEN [NV] = '{1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0};
  localparam int VEC_LAT  [NV] = '{5*D, 0, D, D, 5*D, D};
  localparam int VEC_FIN  [NV] = '{'h00, 'h00, 'hFF, 'hFF, 'h00, 'hFF};

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       reqValid = 1'b0;
  logic       reqOpen = 1'b0;
  logic       reqReady;
  logic [7:0] ctrlWord;
  logic       seqDone;

  int checks = 0;
  int fails = 0;

  always #4 clk = ~clk;

  pwr_ramp_seq #(.DWELL(D)) u0 (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .reqOpen  (reqOpen),
    .reqReady (reqReady),
    .ctrlWord (ctrlWord),
    .seqDone  (seqDone)
  );

  function automatic int openCode(input int step);
    case (step)
      0: openCode = 'hFF;
      1: openCode = 'hFE;
      2: openCode = 'hF8;
      3: openCode = 'hF0;
      default: openCode = 'h00;
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  // One request; optionally a conflicting request is held during the run
  task automatic runReq(input bit isOpen, input int expLat, input int expFin,
                        input bit pokeBusy);
    int k;
    bit traceOk;
    bit sawReady;
    int badAct;
    int badExp;
    int expW;
    @(negedge clk);
    check(reqReady == 1'b1, "R8", "ready before request", int'(reqReady), 1);
    reqValid = 1'b1;
    reqOpen  = isOpen;
    @(negedge clk);
    if (pokeBusy) reqOpen = !isOpen;
    else reqValid = 1'b0;
    k = 0;
    traceOk = 1'b1;
    sawReady = 1'b0;
    badAct = 0;
    badExp = 0;
    while (!seqDone && k < 6*D + 4) begin
      expW = isOpen ? openCode(k / D) : 'hFF;
      if (int'(ctrlWord) != expW && traceOk) begin
        traceOk = 1'b0;
        badAct = int'(ctrlWord);
        badExp = expW;
      end
      if (reqReady) sawReady = 1'b1;
      @(negedge clk);
      k++;
    end
    reqValid = 1'b0;
    check(traceOk, "R2 R3 R6 R9", "code trace", badAct, badExp);
    check(k == expLat, "R4 R5 R6", "done cycle", k, expLat);
    check(int'(ctrlWord) == expFin, "R5 R6", "final word", int'(ctrlWord), expFin);
    check(!sawReady, pokeBusy ? "R7" : "R4", "ready low while busy", int'(sawReady), 0);
    check(reqReady == 1'b0, "R4", "ready during done", int'(reqReady), 0);
    @(negedge clk);
    check(seqDone == 1'b0, "R4", "done width", int'(seqDone), 0);
    check(reqReady == 1'b1, "R4", "ready after done", int'(reqReady), 1);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    $display("FAIL watchdog: actual hung expected finish");
    checks++;
    fails++;
    summary();
    $finish;
  end

  initial begin
    logic [7:0] held;
    // R1: reset state
    repeat (2) @(negedge clk);
    check(ctrlWord == 8'hFF, "R1", "word in reset", int'(ctrlWord), 'hFF);
    check(reqReady == 1'b1, "R1", "ready in reset", int'(reqReady), 1);
    check(seqDone == 1'b0, "R1", "done in reset", int'(seqDone), 0);
    rstN = 1'b1;
    // R8: idle word stable without requests
    held = ctrlWord;
    repeat (5) @(negedge clk);
    check(ctrlWord == held, "R8", "idle word stable", int'(ctrlWord), int'(held));

    for (int i = 0; i < NV; i++) begin
      runReq(VEC_OPEN[i], VEC_LAT[i], VEC_FIN[i], 1'b0);
    end

    // R8: idle at open word
    runReq(1'b1, 5*D, 'h00, 1'b0);
    repeat (4) @(negedge clk);
    check(ctrlWord == 8'h00, "R8", "idle open word stable", int'(ctrlWord), 'h00);

    // R7: a conflicting request is held during a close and during an open
    runReq(1'b0, D, 'hFF, 1'b1);
    runReq(1'b1, 5*D, 'h00, 1'b1);
    // R5: a skip right after a disturbed open
    runReq(1'b1, 0, 'h00, 1'b0);
    runReq(1'b0, D, 'hFF, 1'b0);

    // R1: reset in the middle of an open ramp
    @(negedge clk);
    reqValid = 1'b1;
    reqOpen  = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    repeat (2*D) @(negedge clk);
    check(ctrlWord != 8'hFF, "R1", "ramp under way", int'(ctrlWord), 'hF8);
    rstN = 1'b0;
    #1;
    check(ctrlWord == 8'hFF, "R1", "word after mid reset", int'(ctrlWord), 'hFF);
    check(reqReady == 1'b1, "R1", "ready after mid reset", int'(reqReady), 1);
    check(seqDone == 1'b0, "R1", "done after mid reset", int'(seqDone), 0);
    @(negedge clk);
    rstN = 1'b1;
    runReq(1'b1, 5*D, 'h00, 1'b0);

    summary();
    $finish;
  end

endmodule